// File: doc/BRIEF.md
# Dual-Order Burst Address Generator

This block forms the word address for a four-beat burst in a synchronous burst memory. When the cycle controller pulses the start input, the block captures the external address. It then presents that address as the first beat. Every later cycle in which the active-low step input is low moves the low two bits to the next beat. The upper bits stay equal to the captured address for the whole burst.

A static order input chooses the beat order. With the input high, the order is interleaved: the low bits are the captured start bits XOR the beat count. With the input low, the order is linear: the start bits plus the beat count, wrapping modulo four. When the step input is high, the current address is held, which suspends the burst. After the fourth beat, one more step brings the address back to the start address rather than stopping.

Internally a small state machine has three states. ST_IDLE is the state after reset, before any burst starts. ST_RUN follows a start or a step. ST_HOLD follows a suspended cycle. A start pulse in any state moves the machine to ST_RUN with the beat count cleared. From ST_RUN or ST_HOLD, a low step input moves to ST_RUN and counts up one beat, and a high step input moves to ST_HOLD. ST_IDLE stays in ST_IDLE until a start arrives.

Top module: `burst_addr_gen`

## Requirements
- R1: During a burst, the upper address bits (addr_out[ADDR_W-1:2]) equal the upper bits of the external address captured by the most recent start.
- R2: When start is high at a clock edge, the next output equals the ext_addr sampled at that edge, whatever the value of step_n.
- R3: With order_ilv = 1, the k-th step after a start gives low bits equal to start_bits XOR k (mod 4), so a start of 2'b01 gives 01, 00, 11, 10.
- R4: With order_ilv = 0, the k-th step after a start gives low bits equal to (start_bits + k) mod 4, so a start of 2'b11 gives 11, 00, 01, 10.
- R5: With step_n high and start low at an edge, the output does not change.
- R6: The fourth step after a start brings the low bits back to the start bits, in both orders.
- R7: After reset, addr_out is zero, and step_n pulses before the first start leave it at zero.
- R8: A start in the middle of a burst abandons the old burst. The new start address appears on the next cycle, and later steps count from the new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External start address |
| start | input | 1 | Start pulse from the cycle controller; captures ext_addr |
| step_n | input | 1 | Active-low advance strobe |
| order_ilv | input | 1 | Static order select: 1 for interleaved, 0 for linear |
| addr_out | output | ADDR_W | Current burst address |

## Verification
On every cycle, the assertions check that a start shows the captured address on the next cycle. They also check that a suspended cycle holds the output, that the upper bits never change without a start, and that nothing moves before the first start. For steps, they check that a linear step adds one to the low bits and that an interleaved step toggles bit 0. Bit 1 of the interleaved order depends on the beat position, so only the bench's full sequences can show it. The same holds for the wrap back to the start address, for restarts in mid-burst, and for mixed suspend-and-step patterns.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } bst_state_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step_n,
    output logic [BEAT_W-1:0] beat
);
    bst_state_t state_q, state_d;
    logic       clr_beat, inc_beat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        clr_beat = 1'b0;
        inc_beat = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_RUN;
                    clr_beat = 1'b1;
                end
            end
            ST_RUN, ST_HOLD: begin
                if (start) begin
                    state_d  = ST_RUN;
                    clr_beat = 1'b1;
                end else if (!step_n) begin
                    state_d  = ST_RUN;
                    inc_beat = 1'b1;
                end else begin
                    state_d  = ST_HOLD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        beat <= '0;
        else if (clr_beat) beat <= '0;
        else if (inc_beat) beat <= beat + 1'b1;
    end
endmodule

// File: rtl/addr_map.sv
module addr_map #(
    parameter int BEAT_W = 2
) (
    input  logic              order_ilv,
    input  logic [BEAT_W-1:0] start_bits,
    input  logic [BEAT_W-1:0] beat,
    output logic [BEAT_W-1:0] low_bits
);
    logic [BEAT_W-1:0] ilv_bits, lin_bits;

    assign ilv_bits = start_bits ^ beat;
    assign lin_bits = start_bits + beat;
    assign low_bits = order_ilv ? ilv_bits : lin_bits;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int ADDR_W    = 16,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              start,
    input  logic              step_n,
    input  logic              order_ilv,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int BEAT_W = $clog2(BURST_LEN);

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     base_q <= '0;
        else if (start) base_q <= ext_addr;
    end

    burst_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .step_n (step_n),
        .beat   (beat)
    );

    addr_map #(.BEAT_W(BEAT_W)) u_map (
        .order_ilv  (order_ilv),
        .start_bits (base_q[BEAT_W-1:0]),
        .beat       (beat),
        .low_bits   (low_bits)
    );

    assign addr_out = {base_q[ADDR_W-1:BEAT_W], low_bits};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              start,
    input logic              step_n,
    input logic              order_ilv,
    input logic [ADDR_W-1:0] addr_out
);
    logic seen_start;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     seen_start <= 1'b0;
        else if (start) seen_start <= 1'b1;
    end

    AST_START_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> addr_out == $past(ext_addr)); // R2
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && step_n && $stable(order_ilv)) |=> $stable(addr_out)); // R5
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])); // R1
    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_start && !start && !step_n && !order_ilv)
        |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1); // R4
    AST_ILV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_start && !start && !step_n && order_ilv)
        |=> addr_out[0] != $past(addr_out[0])); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_start |-> addr_out == '0); // R7
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .start     (start),
    .step_n    (step_n),
    .order_ilv (order_ilv),
    .addr_out  (addr_out)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          start = 1'b0;
    logic          step_n = 1'b1;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] addr_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen u_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .start(start),
        .step_n(step_n), .order_ilv(order_ilv), .addr_out(addr_out)
    );

    task automatic check(input string req, input logic [AW-1:0] exp);
        total++;
        if (addr_out !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, addr_out, exp);
        end
    endtask

    // one clock edge, then settle away from the edge
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    function automatic logic [1:0] beat_of(input logic ilv, input logic [1:0] s, input int k);
        logic [1:0] kk = 2'(k);
        return ilv ? (s ^ kk) : (s + kk);
    endfunction

    task automatic t_reset_idle();
        check("R7", '0);
        step_n = 1'b0;
        repeat (3) tick();
        check("R7", '0);
        step_n = 1'b1;
    endtask

    task automatic t_burst(input logic ilv, input logic [AW-1:0] a, input string req);
        order_ilv = ilv;
        ext_addr = a;
        start = 1'b1;
        step_n = 1'b0;
        tick();
        start = 1'b0;
        ext_addr = ~a;
        check("R2", a);
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(k == 4 ? "R6" : req, {a[AW-1:2], beat_of(ilv, a[1:0], k)});
        end
        check("R1", {a[AW-1:2], addr_out[1:0]});
        step_n = 1'b1;
    endtask

    task automatic t_suspend();
        logic [AW-1:0] a = 16'h5A3E;
        order_ilv = 1'b0;
        ext_addr = a;
        start = 1'b1;
        step_n = 1'b1;
        tick();
        start = 1'b0;
        check("R2", a);
        step_n = 1'b0;
        tick();
        check("R4", {a[AW-1:2], 2'b11});
        step_n = 1'b1;
        repeat (3) tick();
        check("R5", {a[AW-1:2], 2'b11});
        step_n = 1'b0;
        tick();
        check("R4", {a[AW-1:2], 2'b00});
        step_n = 1'b1;
    endtask

    task automatic t_restart();
        logic [AW-1:0] a = 16'h1235;
        logic [AW-1:0] b = 16'hC0DE;
        order_ilv = 1'b1;
        ext_addr = a;
        start = 1'b1;
        step_n = 1'b0;
        tick();
        start = 1'b0;
        tick();
        check("R3", {a[AW-1:2], 2'b00});
        ext_addr = b;
        start = 1'b1;
        tick();
        start = 1'b0;
        check("R8", b);
        tick();
        check("R8", {b[AW-1:2], 2'b11});
        tick();
        check("R8", {b[AW-1:2], 2'b00});
        step_n = 1'b1;
    endtask

    initial begin
        #3;
        t_reset_idle();
        rst_n = 1'b1;
        tick();
        t_reset_idle();
        for (int s = 0; s < 4; s++) begin
            t_burst(1'b1, 16'hA5F0 | 16'(s), "R3");
            t_burst(1'b0, 16'h3C40 | 16'(s), "R4");
        end
        t_suspend();
        t_restart();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule